// File: doc/BRIEF.md
# Dual-Link CRC Redundancy Selector

The block takes the same stream of events on two redundant 16-bit links, a primary and a secondary. Each 32-bit event word arrives as two 16-bit halves, high half first. An event starts with a header word and ends with a trailer word. The word just before the trailer carries a CRC16 whose low 16 bits must match a checksum over the payload. Each link frames its events and checks that CRC as the words arrive. It also stores each event in its own buffer, which holds one maximum-size event.

Once the two copies of an event have been judged, exactly one copy is replayed on the single 16-bit output and the other copy is dropped from its buffer. The primary copy is preferred. If the primary copy fails, a good secondary copy is sent. If both fail, a complete copy is still sent, because the downstream consumer must always get the event. Each failure raises a one-cycle pulse on a per-link, per-type error output that feeds an external counter. A status bit reports which link the event now on the output came from.

Each link receiver has two states. R_HUNT waits for a header: a header moves it to R_BODY, and a trailer there is a framing error. R_BODY stores words until a trailer returns it to R_HUNT, or until the link drops, which aborts the event and also returns to R_HUNT. The chooser has four states:
- C_WAIT_P takes the primary record. A good primary goes to C_SEND and then C_DROP. A failed primary goes to C_WAIT_S. A dead primary goes to C_WAIT_S once the secondary has a record.
- C_WAIT_S decides between the two copies and then goes to C_SEND, or back to C_WAIT_P when no copy is complete.
- C_SEND replays the chosen copy and then goes to C_DROP or C_WAIT_P.
- C_DROP discards the secondary copy and then goes back to C_WAIT_P.

Top module: `redun_crc_select`

## Requirements
- R1: When the primary copy passes its CRC check, the primary copy is forwarded, the secondary copy of the same event is discarded, and out_sel reads 0 during that event.
- R2: When the primary copy fails and the secondary copy passes, the secondary copy is forwarded with out_sel at 1, even when the secondary copy arrives many cycles after the primary.
- R3: When both copies fail their CRC check, the primary copy is still forwarded unchanged.
- R4: The CRC uses polynomial 0x1021 and starts at 0xFFFF. It processes each 16-bit half MSB first, high half before low half. It covers every word after the header (0x51115110) up to, but not including, the last word before the trailer (0x3FFF3FF0). Only the low 16 bits of that last word are compared, so its high 16 bits have no effect on the result.
- R5: Each copy that fails its CRC produces exactly one single-cycle pulse on crc_err, at bit 0 for the primary and bit 1 for the secondary.
- R6: A trailer that arrives on a link with no header before it produces one frm_err pulse for that link and counts as that link's failed copy for the next event.
- R7: A falling link_up produces one down_err pulse for that link. While a link is down, an event delivered on the other link is judged without it.
- R8: The forwarded event runs from its header to its trailer. Each 32-bit word is output as its high half and then its low half, on consecutive cycles with out_valid high. The content is unchanged.
- R9: out_sel takes its new value when an event starts on the output and holds steady until that event ends.
- R10: Words that arrive on a link outside an event, before a header, have no effect on the output.
- R11: After reset, out_valid, out_sel and all error outputs are 0.
- R12: Each link buffers a complete event while the other copy is awaited or another event is replayed, so events sent back to back are forwarded in order without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_up | input | 1 | Primary link is up |
| pri_data | input | 16 | Primary link half-word |
| pri_valid | input | 1 | Primary half-word valid |
| sec_up | input | 1 | Secondary link is up |
| sec_data | input | 16 | Secondary link half-word |
| sec_valid | input | 1 | Secondary half-word valid |
| out_data | output | 16 | Forwarded half-word |
| out_valid | output | 1 | Forwarded half-word valid |
| out_sel | output | 1 | Link of the event on the output (0 primary, 1 secondary) |
| crc_err | output | 2 | CRC failure pulse per link |
| frm_err | output | 2 | Framing failure pulse per link |
| down_err | output | 2 | Link-drop pulse per link |

## Verification
The bench covers the following corner cases, each with the fault it would expose:
- A primary with a bad CRC next to a good secondary: a selector that ignored the check would send the corrupted primary.
- Both copies bad: a design that drops doubly failed events would leave the output silent.
- A secondary that arrives late: a design that decides too early would emit the bad primary.
- A CRC word whose high half is non-zero: a full 32-bit compare would wrongly reject the primary.
- An empty event, whose expected checksum is the seed.
- A stray trailer, a dead primary and stray pre-header words: each probes framing and alignment.
- Back-to-back events: an off-by-one discard of the unused copy would shift every later event.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam logic [31:0] RCS_HDR  = 32'h5111_5110;
    localparam logic [31:0] RCS_TRL  = 32'h3FFF_3FF0;
    localparam logic [15:0] RCS_POLY = 16'h1021;
    localparam logic [15:0] RCS_SEED = 16'hFFFF;

    typedef enum logic {R_HUNT, R_BODY} rx_state_e;

    typedef enum logic [1:0] {C_WAIT_P, C_WAIT_S, C_SEND, C_DROP} ch_state_e;

    // One 16-bit half, MSB first
    function automatic logic [15:0] crc16_half(input logic [15:0] crc_in,
                                               input logic [15:0] d);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 15; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0} ^ (fb ? RCS_POLY : 16'h0000);
        end
        return c;
    endfunction

    // One 32-bit word, high half first
    function automatic logic [15:0] crc16_word(input logic [15:0] crc_in,
                                               input logic [31:0] w);
        return crc16_half(crc16_half(crc_in, w[31:16]), w[15:0]);
    endfunction

endpackage

// File: rtl/rcs_buffer.sv
module rcs_buffer #(
    parameter int DEPTH = 1024,   // power of two
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_adv,
    input  logic             skip_en,
    input  logic [LW-1:0]    skip_len,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    lvl_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + AW'(1);
            if (rd_adv) rd_ptr <= rd_ptr + AW'(1);
            else if (skip_en) rd_ptr <= rd_ptr + skip_len[AW-1:0];
            lvl_q <= lvl_q + LW'(wr_en) - LW'(rd_adv)
                     - (skip_en ? skip_len : LW'(0));
        end
    end

    assign rd_data = mem[rd_ptr];
    assign level   = lvl_q;

    // R12: an event never overruns the per-link store
    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (lvl_q < LW'(DEPTH)));
    // R12: reads and discards only touch stored words
    a_r12_no_underread: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |-> (lvl_q != '0));
    a_r12_skip_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        skip_en |-> (skip_len <= lvl_q));
    a_r12_one_read_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_adv && skip_en));

endmodule

// File: rtl/rcs_link_rx.sv
module rcs_link_rx
    import rcs_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int RQ_DEPTH = 4,     // power of two
    localparam int LW  = $clog2(DEPTH + 1),
    localparam int RQW = $clog2(RQ_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic [15:0]   in_data,
    input  logic          in_valid,
    output logic          alive,
    output logic          rec_valid,
    output logic          rec_ok,
    output logic          rec_cmp,
    output logic [LW-1:0] rec_len,
    input  logic          rec_pop,
    input  logic          rd_adv,
    input  logic          skip_en,
    input  logic [LW-1:0] skip_len,
    output logic [31:0]   rd_word,
    output logic          crc_err,
    output logic          frm_err,
    output logic          down_err
);

    // half-word pairing
    logic        hi_have;
    logic [15:0] hi_q;
    logic        word_stb;
    logic [31:0] word;

    assign word_stb = link_up && in_valid && hi_have;
    assign word     = {hi_q, in_data};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_have <= 1'b0;
            hi_q    <= '0;
        end else if (!link_up) begin
            hi_have <= 1'b0;
        end else if (in_valid) begin
            if (!hi_have) hi_q <= in_data;
            hi_have <= !hi_have;
        end
    end

    // framing and CRC state
    rx_state_e     st, st_n;
    logic [15:0]   crc_q, crc_n;
    logic [31:0]   prev_q, prev_n;
    logic          hp_q, hp_n;
    logic [LW-1:0] len_q, len_n;
    logic          link_q;

    logic          wr_en, push, p_ok, p_cmp, crc_pulse, frm_pulse;
    logic [LW-1:0] p_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= R_HUNT;
            crc_q    <= RCS_SEED;
            prev_q   <= '0;
            hp_q     <= 1'b0;
            len_q    <= '0;
            link_q   <= 1'b0;
            crc_err  <= 1'b0;
            frm_err  <= 1'b0;
            down_err <= 1'b0;
        end else begin
            st       <= st_n;
            crc_q    <= crc_n;
            prev_q   <= prev_n;
            hp_q     <= hp_n;
            len_q    <= len_n;
            link_q   <= link_up;
            crc_err  <= crc_pulse;
            frm_err  <= frm_pulse;
            down_err <= link_q && !link_up;
        end
    end

    always_comb begin
        st_n      = st;
        crc_n     = crc_q;
        prev_n    = prev_q;
        hp_n      = hp_q;
        len_n     = len_q;
        wr_en     = 1'b0;
        push      = 1'b0;
        p_ok      = 1'b0;
        p_cmp     = 1'b0;
        p_len     = '0;
        crc_pulse = 1'b0;
        frm_pulse = 1'b0;
        unique case (st)
            R_HUNT: begin
                if (word_stb) begin
                    if (word == RCS_HDR) begin
                        wr_en = 1'b1;
                        len_n = LW'(1);
                        crc_n = RCS_SEED;
                        hp_n  = 1'b0;
                        st_n  = R_BODY;
                    end else if (word == RCS_TRL) begin
                        push      = 1'b1;
                        frm_pulse = 1'b1;
                    end
                end
            end
            R_BODY: begin
                if (!link_up) begin
                    push  = 1'b1;
                    p_len = len_q;
                    st_n  = R_HUNT;
                end else if (word_stb) begin
                    wr_en = 1'b1;
                    len_n = len_q + LW'(1);
                    if (word == RCS_TRL) begin
                        push      = 1'b1;
                        p_len     = len_q + LW'(1);
                        p_cmp     = 1'b1;
                        p_ok      = hp_q && (prev_q[15:0] == crc_q);
                        crc_pulse = !(hp_q && (prev_q[15:0] == crc_q));
                        st_n      = R_HUNT;
                    end else begin
                        if (hp_q) crc_n = crc16_word(crc_q, prev_q);
                        prev_n = word;
                        hp_n   = 1'b1;
                    end
                end
            end
        endcase
    end

    assign alive = link_q;

    // result queue, one entry per event slot
    logic          q_ok  [RQ_DEPTH];
    logic          q_cmp [RQ_DEPTH];
    logic [LW-1:0] q_len [RQ_DEPTH];
    logic [RQW-1:0] q_wp, q_rp;
    logic [RQW:0]   q_cnt;

    always_ff @(posedge clk) begin
        if (push) begin
            q_ok[q_wp]  <= p_ok;
            q_cmp[q_wp] <= p_cmp;
            q_len[q_wp] <= p_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_wp  <= '0;
            q_rp  <= '0;
            q_cnt <= '0;
        end else begin
            if (push)    q_wp <= q_wp + RQW'(1);
            if (rec_pop) q_rp <= q_rp + RQW'(1);
            q_cnt <= q_cnt + (RQW+1)'(push) - (RQW+1)'(rec_pop);
        end
    end

    assign rec_valid = (q_cnt != '0);
    assign rec_ok    = q_ok[q_rp];
    assign rec_cmp   = q_cmp[q_rp];
    assign rec_len   = q_len[q_rp];

    logic [LW-1:0] buf_level;

    rcs_buffer #(.DEPTH(DEPTH), .WIDTH(32)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (word),
        .rd_adv   (rd_adv),
        .skip_en  (skip_en),
        .skip_len (skip_len),
        .rd_data  (rd_word),
        .level    (buf_level)
    );

    // R5: CRC failure is a single-cycle pulse
    a_r5_crc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err);
    // R6: framing failure is a single-cycle pulse
    a_r6_frm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |=> !frm_err);
    // R12: result queue never overruns
    a_r12_rec_room: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rec_pop) |-> (q_cnt < (RQW+1)'(RQ_DEPTH)));
    // R12: a popped record always has its words stored
    a_r12_words_present: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_pop && rec_valid) |-> (rec_len <= buf_level));

endmodule

// File: rtl/rcs_chooser.sv
module rcs_chooser
    import rcs_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           alive,
    input  logic [1:0]           rec_valid,
    input  logic [1:0]           rec_ok,
    input  logic [1:0]           rec_cmp,
    input  logic [1:0][LW-1:0]   rec_len,
    output logic [1:0]           rec_pop,
    output logic [1:0]           rd_adv,
    output logic [1:0]           skip_en,
    output logic [1:0][LW-1:0]   skip_len,
    input  logic [1:0][31:0]     rd_word,
    output logic [15:0]          out_data,
    output logic                 out_valid,
    output logic                 out_sel
);

    ch_state_e     st, st_n;
    logic          p_have, p_have_n, p_cmp, p_cmp_n;
    logic [LW-1:0] p_len, p_len_n;
    logic          sel_q, sel_n;
    logic [LW-1:0] slen_q, slen_n, cnt_q, cnt_n;
    logic          half_q, half_n, drop_q, drop_n;
    logic          s_have, s_ok, s_cmp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= C_WAIT_P;
            p_have <= 1'b0;
            p_cmp  <= 1'b0;
            p_len  <= '0;
            sel_q  <= 1'b0;
            slen_q <= '0;
            cnt_q  <= '0;
            half_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            st     <= st_n;
            p_have <= p_have_n;
            p_cmp  <= p_cmp_n;
            p_len  <= p_len_n;
            sel_q  <= sel_n;
            slen_q <= slen_n;
            cnt_q  <= cnt_n;
            half_q <= half_n;
            drop_q <= drop_n;
        end
    end

    always_comb begin
        st_n     = st;
        p_have_n = p_have;
        p_cmp_n  = p_cmp;
        p_len_n  = p_len;
        sel_n    = sel_q;
        slen_n   = slen_q;
        cnt_n    = cnt_q;
        half_n   = half_q;
        drop_n   = drop_q;
        rec_pop  = '0;
        rd_adv   = '0;
        skip_en  = '0;
        skip_len = '0;
        s_have   = rec_valid[1];
        s_ok     = rec_valid[1] && rec_ok[1];
        s_cmp    = rec_valid[1] && rec_cmp[1];
        unique case (st)
            C_WAIT_P: begin
                if (rec_valid[0]) begin
                    rec_pop[0] = 1'b1;
                    if (rec_ok[0]) begin
                        sel_n  = 1'b0;
                        slen_n = rec_len[0];
                        cnt_n  = '0;
                        half_n = 1'b0;
                        drop_n = 1'b1;
                        st_n   = C_SEND;
                    end else begin
                        p_have_n = 1'b1;
                        p_cmp_n  = rec_cmp[0];
                        p_len_n  = rec_len[0];
                        st_n     = C_WAIT_S;
                    end
                end else if (!alive[0] && rec_valid[1]) begin
                    p_have_n = 1'b0;
                    p_cmp_n  = 1'b0;
                    p_len_n  = '0;
                    st_n     = C_WAIT_S;
                end
            end
            C_WAIT_S: begin
                if (s_have || (!alive[1] && p_have)) begin
                    rec_pop[1] = s_have;
                    drop_n     = 1'b0;
                    cnt_n      = '0;
                    half_n     = 1'b0;
                    if (s_ok || (!(p_have && p_cmp) && s_cmp)) begin
                        sel_n       = 1'b1;
                        slen_n      = rec_len[1];
                        skip_en[0]  = p_have;
                        skip_len[0] = p_len;
                        st_n        = C_SEND;
                    end else if (p_have && p_cmp) begin
                        sel_n       = 1'b0;
                        slen_n      = p_len;
                        skip_en[1]  = s_have;
                        skip_len[1] = rec_len[1];
                        st_n        = C_SEND;
                    end else begin
                        skip_en[0]  = p_have;
                        skip_len[0] = p_len;
                        skip_en[1]  = s_have;
                        skip_len[1] = rec_len[1];
                        st_n        = C_WAIT_P;
                    end
                end
            end
            C_SEND: begin
                half_n = !half_q;
                if (half_q) begin
                    rd_adv[sel_q] = 1'b1;
                    cnt_n         = cnt_q + LW'(1);
                    if (cnt_q == slen_q - LW'(1))
                        st_n = drop_q ? C_DROP : C_WAIT_P;
                end
            end
            C_DROP: begin
                if (rec_valid[1]) begin
                    rec_pop[1]  = 1'b1;
                    skip_en[1]  = 1'b1;
                    skip_len[1] = rec_len[1];
                    st_n        = C_WAIT_P;
                end else if (!alive[1]) begin
                    st_n = C_WAIT_P;
                end
            end
        endcase
    end

    always_comb begin
        out_valid = (st == C_SEND);
        out_sel   = sel_q;
        out_data  = '0;
        if (st == C_SEND)
            out_data = half_q ? rd_word[sel_q][15:0] : rd_word[sel_q][31:16];
    end

    // R8: every forwarded event opens with the header high half
    a_r8_starts_with_header: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == RCS_HDR[31:16]));
    // R8: and closes with the trailer low half
    a_r8_ends_with_trailer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> ($past(out_data) == RCS_TRL[15:0]));
    // R9: the link indicator holds through an event
    a_r9_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(out_sel));
    // R1: only one copy is replayed at a time
    a_r1_single_reader: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_adv));

endmodule

// File: rtl/redun_crc_select.sv
module redun_crc_select #(
    parameter int DEPTH    = 1024,
    parameter int RQ_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pri_up,
    input  logic [15:0] pri_data,
    input  logic        pri_valid,
    input  logic        sec_up,
    input  logic [15:0] sec_data,
    input  logic        sec_valid,
    output logic [15:0] out_data,
    output logic        out_valid,
    output logic        out_sel,
    output logic [1:0]  crc_err,
    output logic [1:0]  frm_err,
    output logic [1:0]  down_err
);

    localparam int LW = $clog2(DEPTH + 1);

    logic [1:0]         up_v, val_v;
    logic [1:0][15:0]   dat_v;
    logic [1:0]         alive, rec_valid, rec_ok, rec_cmp, rec_pop;
    logic [1:0]         rd_adv, skip_en;
    logic [1:0][LW-1:0] rec_len, skip_len;
    logic [1:0][31:0]   rd_word;

    assign up_v  = {sec_up, pri_up};
    assign val_v = {sec_valid, pri_valid};
    assign dat_v = {sec_data, pri_data};

    for (genvar g = 0; g < 2; g++) begin : g_link
        rcs_link_rx #(.DEPTH(DEPTH), .RQ_DEPTH(RQ_DEPTH)) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .link_up   (up_v[g]),
            .in_data   (dat_v[g]),
            .in_valid  (val_v[g]),
            .alive     (alive[g]),
            .rec_valid (rec_valid[g]),
            .rec_ok    (rec_ok[g]),
            .rec_cmp   (rec_cmp[g]),
            .rec_len   (rec_len[g]),
            .rec_pop   (rec_pop[g]),
            .rd_adv    (rd_adv[g]),
            .skip_en   (skip_en[g]),
            .skip_len  (skip_len[g]),
            .rd_word   (rd_word[g]),
            .crc_err   (crc_err[g]),
            .frm_err   (frm_err[g]),
            .down_err  (down_err[g])
        );
    end

    rcs_chooser #(.DEPTH(DEPTH)) u_choose (
        .clk       (clk),
        .rst_n     (rst_n),
        .alive     (alive),
        .rec_valid (rec_valid),
        .rec_ok    (rec_ok),
        .rec_cmp   (rec_cmp),
        .rec_len   (rec_len),
        .rec_pop   (rec_pop),
        .rd_adv    (rd_adv),
        .skip_en   (skip_en),
        .skip_len  (skip_len),
        .rd_word   (rd_word),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sel   (out_sel)
    );

endmodule

// File: tb/redun_crc_select_bench.sv
`timescale 1ns/1ps
module redun_crc_select_bench;

    localparam logic [31:0] HDR = 32'h5111_5110;
    localparam logic [31:0] TRL = 32'h3FFF_3FF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pri_up = 1'b1, sec_up = 1'b1;
    logic [15:0] pri_data = '0, sec_data = '0;
    logic        pri_valid = 1'b0, sec_valid = 1'b0;
    logic [15:0] out_data;
    logic        out_valid, out_sel;
    logic [1:0]  crc_err, frm_err, down_err;

    always #5 clk = ~clk;

    redun_crc_select u_redun_crc_select (
        .clk(clk), .rst_n(rst_n),
        .pri_up(pri_up), .pri_data(pri_data), .pri_valid(pri_valid),
        .sec_up(sec_up), .sec_data(sec_data), .sec_valid(sec_valid),
        .out_data(out_data), .out_valid(out_valid), .out_sel(out_sel),
        .crc_err(crc_err), .frm_err(frm_err), .down_err(down_err)
    );

    typedef struct packed { logic s; logic [15:0] d; } exp_t;
    exp_t  expq[$];
    string tagq[$];

    int checks = 0, fails = 0;
    int n_crc[2], n_frm[2], n_down[2];
    int e_crc[2], e_frm[2], e_down[2];

    logic [31:0] ev [2][64];
    int n_ev[2];
    int first_w[2];
    int cnt_w[2];

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // CRC reference: 0x1021, seed 0xFFFF, 32 bits MSB first per word
    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [31:0] w);
        logic [15:0] c = c0;
        for (int b = 31; b >= 0; b--) begin
            if (c[15] ^ w[b]) c = (c << 1) ^ 16'h1021;
            else              c = c << 1;
        end
        return c;
    endfunction

    task automatic build(input int l, input int np, input logic [31:0] seed,
                         input logic [15:0] flip, input logic [15:0] upper,
                         input bit app);
        logic [15:0] c = 16'hFFFF;
        int k = app ? n_ev[l] : 0;
        first_w[l] = k;
        ev[l][k++] = HDR;
        for (int i = 0; i < np; i++) begin
            ev[l][k] = seed + 32'h0103_0507 * i;
            c = ref_crc(c, ev[l][k]);
            k++;
        end
        ev[l][k++] = {upper, c ^ flip};
        ev[l][k++] = TRL;
        n_ev[l] = k;
        cnt_w[l] = np + 3;
    endtask

    task automatic expect_ev(input int l, input logic s, input string tag);
        for (int i = first_w[l]; i < first_w[l] + cnt_w[l]; i++) begin
            expq.push_back({s, ev[l][i][31:16]}); tagq.push_back(tag);
            expq.push_back({s, ev[l][i][15:0]});  tagq.push_back(tag);
        end
    endtask

    task automatic drive_link(input int l);
        for (int i = 0; i < n_ev[l]; i++) begin
            for (int h = 0; h < 2; h++) begin
                if (l == 0) begin
                    pri_data  = h ? ev[l][i][15:0] : ev[l][i][31:16];
                    pri_valid = 1'b1;
                end else begin
                    sec_data  = h ? ev[l][i][15:0] : ev[l][i][31:16];
                    sec_valid = 1'b1;
                end
                @(posedge clk); #1;
            end
        end
        if (l == 0) pri_valid = 1'b0; else sec_valid = 1'b0;
    endtask

    task automatic run_pair(input int lag);
        fork
            drive_link(0);
            begin #(lag * 10); drive_link(1); end
        join
    endtask

    task automatic drain();
        while (expq.size() != 0) @(posedge clk);
        repeat (20) @(posedge clk);
        #1;
        for (int l = 0; l < 2; l++) begin
            chk(n_crc[l] == e_crc[l], "R5 crc_err count", n_crc[l], e_crc[l]);
            chk(n_frm[l] == e_frm[l], "R6 frm_err count", n_frm[l], e_frm[l]);
            chk(n_down[l] == e_down[l], "R7 down_err count", n_down[l], e_down[l]);
        end
    endtask

    // monitor / scoreboard
    exp_t  m_e;
    string m_t;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < 2; l++) begin
                if (crc_err[l])  n_crc[l]++;
                if (frm_err[l])  n_frm[l]++;
                if (down_err[l]) n_down[l]++;
            end
            if (out_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R8 unexpected output", out_data, 0);
                end else begin
                    m_e = expq.pop_front();
                    m_t = tagq.pop_front();
                    chk(out_data == m_e.d, {m_t, " data"}, out_data, m_e.d);
                    chk(out_sel == m_e.s, {m_t, " R9 out_sel"}, out_sel, m_e.s);
                end
            end
        end
    end

    initial begin
        #1_500_000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int l = 0; l < 2; l++) begin
            n_crc[l] = 0; n_frm[l] = 0; n_down[l] = 0;
            e_crc[l] = 0; e_frm[l] = 0; e_down[l] = 0;
            n_ev[l] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        chk(out_sel == 1'b0, "R11 out_sel", out_sel, 0);
        chk({crc_err, frm_err, down_err} == 6'b0, "R11 errors",
            {crc_err, frm_err, down_err}, 0);
        @(posedge clk); #1;

        // R1 R4: both copies good
        build(0, 3, 32'h0000_1100, 0, 0, 0); build(1, 3, 32'h0000_1100, 0, 0, 0);
        expect_ev(0, 1'b0, "R1 both good"); run_pair(0); drain();

        // R2 R5: primary bad CRC, secondary good
        build(0, 4, 32'h0000_2200, 16'h0001, 0, 0); build(1, 4, 32'h0000_2200, 0, 0, 0);
        expect_ev(1, 1'b1, "R2 primary bad"); e_crc[0]++; run_pair(0); drain();

        // R3: both bad, primary copy still forwarded
        build(0, 2, 32'h0000_3300, 16'h8000, 0, 0); build(1, 2, 32'h0000_3300, 16'h0100, 0, 0);
        expect_ev(0, 1'b0, "R3 both bad"); e_crc[0]++; e_crc[1]++; run_pair(0); drain();

        // R1: primary good, differing secondary discarded
        build(0, 5, 32'h0000_4400, 0, 0, 0); build(1, 5, 32'h0000_4A00, 0, 0, 0);
        expect_ev(0, 1'b0, "R1 secondary dropped"); run_pair(0); drain();

        // R2: secondary arrives late
        build(0, 3, 32'h0000_5500, 16'h0040, 0, 0); build(1, 3, 32'h0000_5500, 0, 0, 0);
        expect_ev(1, 1'b1, "R2 late secondary"); e_crc[0]++; run_pair(40); drain();

        // R4: empty event, CRC equals the seed
        build(0, 0, 0, 0, 0, 0); build(1, 0, 0, 0, 0, 0);
        expect_ev(0, 1'b0, "R4 empty event"); run_pair(0); drain();

        // R4: high half of the CRC word is not compared
        build(0, 2, 32'h0000_6600, 0, 16'hABCD, 0); build(1, 2, 32'h0000_6600, 0, 0, 0);
        expect_ev(0, 1'b0, "R4 upper half ignored"); run_pair(0); drain();

        // R10: stray words before the header
        for (int l = 0; l < 2; l++) begin
            ev[l][0] = 32'h0000_2222; ev[l][1] = 32'h1234_5678; n_ev[l] = 2;
            build(l, 3, 32'h0000_7700, 0, 0, 1);
        end
        expect_ev(0, 1'b0, "R10 stray words"); run_pair(0); drain();

        // R6: trailer without header on the primary
        ev[0][0] = TRL; n_ev[0] = 1; build(1, 3, 32'h0000_8800, 0, 0, 0);
        expect_ev(1, 1'b1, "R6 framing"); e_frm[0]++; run_pair(0); drain();

        // R7: primary link down
        pri_up = 1'b0; e_down[0]++;
        repeat (3) @(posedge clk); #1;
        n_ev[0] = 0; build(1, 4, 32'h0000_9900, 0, 0, 0);
        expect_ev(1, 1'b1, "R7 primary down"); run_pair(0); drain();
        pri_up = 1'b1;
        repeat (3) @(posedge clk); #1;

        // R12: back-to-back events, secondary of the first one bad
        build(0, 3, 32'h0000_A100, 0, 0, 0); build(1, 3, 32'h0000_A100, 16'h0002, 0, 0);
        expect_ev(0, 1'b0, "R12 back-to-back first"); e_crc[1]++;
        build(0, 6, 32'h0000_A200, 16'h0004, 0, 1); build(1, 6, 32'h0000_A200, 0, 0, 1);
        expect_ev(1, 1'b1, "R12 back-to-back second"); e_crc[0]++;
        run_pair(0); drain();

        // R8: long event
        build(0, 40, 32'h0000_B000, 0, 0, 0); build(1, 40, 32'h0000_B000, 0, 0, 0);
        expect_ev(0, 1'b0, "R8 long event"); run_pair(3); drain();

        chk(expq.size() == 0, "R8 all expected output seen", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule